// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a memory-mapped watchdog. A prescaler divides the bus clock, and a 16-bit countdown counter advances once per prescaler period. While the watchdog runs and the countdown expires, the block raises a one-cycle reset request and then starts a new period on its own. Software keeps the system alive by writing the kick register, which restarts the countdown from the programmed reload value.

Each of the four control registers (kick, reload, enable and prescale) sits behind its own guard word. Software unlocks a guard by writing a fixed series of key words. After each write it reads the guard back, and the low two bits show how far the unlock has got. A data write is taken only while its guard shows the open state 3. The enable guard needs three keys and the others need two, so a stray write cannot easily stop the watchdog. Any wrong key closes the guard again. So does a key given out of order, and so does an accepted data write.

The bus has one word address per register and single-cycle writes. Reads are combinational from the address. The eight words are laid out as guard/data pairs: word 2g is the guard of register g and word 2g+1 is its data, with g = 0 kick, 1 reload, 2 enable, 3 prescale.

Top module: `locked_watchdog`

## Requirements
- R1: Reading an even word (a guard) returns its state in bits [1:0] and zero in bits [31:2]. Reading word 1 returns the running count, word 3 the reload value, word 5 the enable flag in bit 0, and word 7 the prescale value, all zero-extended.
- R2: After reset all four guards read 0, the watchdog is disabled, reload and prescale read 0xFFFF, and the reset request is low.
- R3: The kick guard moves from 0 to 1 on the word 0x0000_5555, and from 1 to 3 on the word 0x0000_AAAA.
- R4: The reload guard opens with 0x0000_6666 (to state 1) and then 0x0000_BBBB (to state 3). The prescale guard opens with 0x0000_5A5A (to state 1) and then 0x0000_A5A5 (to state 3).
- R5: The enable guard takes three keys: 0x0000_7777 gives state 1, 0x0000_CCCC gives state 2, and 0x0000_DDDD gives state 3.
- R6: A guard write that is not the next expected key returns that guard to 0. This includes any guard write while the guard is in state 3.
- R7: A data write while its guard is not in state 3 changes neither the register nor the guard state.
- R8: An accepted data write returns its guard to state 0.
- R9: Writing bit 0 = 1 to the open enable register starts the watchdog, and writing bit 0 = 0 stops it. Starting a stopped watchdog reloads the count from the reload value.
- R10: A kick, or a start, reloads the countdown. The reset request rises in the cycle after the (reload × prescale)-th rising edge that follows the loading edge, stays high for one cycle, and a new period begins at once. A reload or prescale value of 0 behaves as 1.
- R11: While the watchdog is stopped, the count does not change (except when loaded by a kick) and the reset request stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, which also feeds the prescaler |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word address |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rst_req | output | 1 | One-cycle reset request when the countdown expires |

## Verification
The assertions assume that reset is high from time zero for at least one clock. They also assume that bus_we is only ever a clean 0 or 1 pulse on the bus. The freeze property assumes that nothing other than a bus write can load the count while the watchdog is stopped, so it is only armed in cycles with no write. The stimulus never changes the prescale value while a period is in progress. It also never combines a reload write and a kick in the same cycle. This keeps the bench's cycle-counting model exact, because a new prescale value only takes effect at the next prescaler wrap.

// File: rtl/lwd_pkg.sv
package lwd_pkg;

    localparam int DATA_W     = 32;
    localparam int KEY_W      = 16;
    localparam int NUM_GUARDS = 4;
    localparam int ADDR_W     = $clog2(2 * NUM_GUARDS);

    // Guard index g: word 2g is the guard, word 2g+1 the guarded register.
    typedef enum logic [1:0] {
        GD_KICK     = 2'd0,
        GD_RELOAD   = 2'd1,
        GD_ENABLE   = 2'd2,
        GD_PRESCALE = 2'd3
    } guard_e;

    typedef logic [1:0] gstate_t;

    localparam gstate_t GS_IDLE = 2'd0;
    localparam gstate_t GS_OPEN = 2'd3;

    typedef struct packed {
        logic              run;
        logic [KEY_W-1:0]  reload;
        logic [KEY_W-1:0]  prescale;
    } wd_cfg_t;

    // Key expected at a given step of a guard's unlock series.
    function automatic logic [KEY_W-1:0] key_at(guard_e g, logic [1:0] step);
        logic [KEY_W-1:0] k;
        k = '0;
        unique case (g)
            GD_KICK:     k = (step == 2'd0) ? 16'h5555 : 16'hAAAA;
            GD_RELOAD:   k = (step == 2'd0) ? 16'h6666 : 16'hBBBB;
            GD_PRESCALE: k = (step == 2'd0) ? 16'h5A5A : 16'hA5A5;
            GD_ENABLE: begin
                case (step)
                    2'd0:    k = 16'h7777;
                    2'd1:    k = 16'hCCCC;
                    default: k = 16'hDDDD;
                endcase
            end
        endcase
        return k;
    endfunction

    function automatic logic is_key(logic [DATA_W-1:0] w, logic [KEY_W-1:0] k);
        return (w[DATA_W-1:KEY_W] == '0) && (w[KEY_W-1:0] == k);
    endfunction

    // Next guard state after a write to the guard word.
    function automatic gstate_t guard_next(guard_e g, gstate_t st, logic [DATA_W-1:0] w);
        gstate_t nx;
        nx = GS_IDLE;
        if (g == GD_ENABLE) begin
            if (st != GS_OPEN && is_key(w, key_at(g, st)))
                nx = st + 2'd1;
        end else begin
            if (st == 2'd0 && is_key(w, key_at(g, 2'd0)))
                nx = 2'd1;
            else if (st == 2'd1 && is_key(w, key_at(g, 2'd1)))
                nx = GS_OPEN;
        end
        return nx;
    endfunction

endpackage

// File: rtl/lwd_guard.sv
module lwd_guard
    import lwd_pkg::*;
#(
    parameter guard_e KIND = GD_KICK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    input  logic              data_wr,
    output gstate_t           state,
    output logic              open
);

    gstate_t st_q;

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= GS_IDLE;
        else if (key_wr)
            st_q <= guard_next(KIND, st_q, key_data);
        else if (data_wr && st_q == GS_OPEN)
            st_q <= GS_IDLE;
    end

    assign state = st_q;
    assign open  = (st_q == GS_OPEN);

endmodule

// File: rtl/lwd_timer.sv
module lwd_timer #(
    parameter int CNT_W = 16,
    parameter int PS_W  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] reload,
    input  logic [PS_W-1:0]  prescale,
    output logic [CNT_W-1:0] count,
    output logic             fire
);

    logic [CNT_W-1:0] eff_rl;
    logic [PS_W-1:0]  eff_ps;
    logic [CNT_W-1:0] cnt_q;
    logic [PS_W-1:0]  pre_q;
    logic             fire_q;

    assign eff_rl = (reload == '0)   ? CNT_W'(1) : reload;
    assign eff_ps = (prescale == '0) ? PS_W'(1)  : prescale;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '1;
            pre_q  <= '0;
            fire_q <= 1'b0;
        end else begin
            fire_q <= 1'b0;
            if (load) begin
                cnt_q <= eff_rl;
                pre_q <= eff_ps - PS_W'(1);
            end else if (run) begin
                if (pre_q != '0) begin
                    pre_q <= pre_q - PS_W'(1);
                end else begin
                    pre_q <= eff_ps - PS_W'(1);
                    if (cnt_q <= CNT_W'(1)) begin
                        fire_q <= 1'b1;
                        cnt_q  <= eff_rl;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
            end
        end
    end

    assign count = cnt_q;
    assign fire  = fire_q;

endmodule

// File: rtl/locked_watchdog.sv
module locked_watchdog
    import lwd_pkg::*;
#(
    parameter int CNT_W = KEY_W,
    parameter int PS_W  = KEY_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              rst_req
);

    localparam int LOCK_FLAT_W = 2 * NUM_GUARDS;

    logic [1:0]             sel;
    logic                   is_data;
    logic [NUM_GUARDS-1:0]  key_wr;
    logic [NUM_GUARDS-1:0]  data_wr;
    logic [NUM_GUARDS-1:0]  open;
    logic [NUM_GUARDS-1:0]  accept;
    gstate_t                lock_st [NUM_GUARDS];
    logic [LOCK_FLAT_W-1:0] lock_flat;

    wd_cfg_t                cfg_q;
    logic                   load;
    logic [CNT_W-1:0]       count_q;
    logic                   en_q;
    logic [CNT_W-1:0]       reload_q;

    assign sel     = bus_addr[2:1];
    assign is_data = bus_addr[0];

    for (genvar g = 0; g < NUM_GUARDS; g++) begin : g_guard
        assign key_wr[g]  = bus_we && !is_data && (sel == 2'(g));
        assign data_wr[g] = bus_we &&  is_data && (sel == 2'(g));
        assign accept[g]  = data_wr[g] && open[g];
        assign lock_flat[2*g +: 2] = lock_st[g];

        lwd_guard #(.KIND(guard_e'(g))) u_guard (
            .clk      (clk),
            .rst      (rst),
            .key_wr   (key_wr[g]),
            .key_data (bus_wdata),
            .data_wr  (data_wr[g]),
            .state    (lock_st[g]),
            .open     (open[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.run      <= 1'b0;
            cfg_q.reload   <= '1;
            cfg_q.prescale <= '1;
        end else begin
            if (accept[GD_RELOAD])
                cfg_q.reload <= bus_wdata[KEY_W-1:0];
            if (accept[GD_ENABLE])
                cfg_q.run <= bus_wdata[0];
            if (accept[GD_PRESCALE])
                cfg_q.prescale <= bus_wdata[KEY_W-1:0];
        end
    end

    assign load = accept[GD_KICK]
               || (accept[GD_ENABLE] && bus_wdata[0] && !cfg_q.run);

    lwd_timer #(.CNT_W(CNT_W), .PS_W(PS_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (cfg_q.run),
        .load     (load),
        .reload   (CNT_W'(cfg_q.reload)),
        .prescale (PS_W'(cfg_q.prescale)),
        .count    (count_q),
        .fire     (rst_req)
    );

    assign en_q     = cfg_q.run;
    assign reload_q = CNT_W'(cfg_q.reload);

    always_comb begin
        bus_rdata = '0;
        if (!is_data) begin
            bus_rdata[1:0] = lock_st[sel];
        end else begin
            unique case (guard_e'(sel))
                GD_KICK:     bus_rdata = 32'(count_q);
                GD_RELOAD:   bus_rdata = 32'(cfg_q.reload);
                GD_ENABLE:   bus_rdata = {31'b0, cfg_q.run};
                GD_PRESCALE: bus_rdata = 32'(cfg_q.prescale);
            endcase
        end
    end

endmodule

// File: rtl/lwd_check.sv
module lwd_check #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       bus_addr,
    input logic             bus_we,
    input logic [31:0]      bus_rdata,
    input logic             rst_req,
    input logic [7:0]       lock_flat,
    input logic             en_q,
    input logic [CNT_W-1:0] reload_q,
    input logic [CNT_W-1:0] count_q
);

    assert_guard_read_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
        !bus_addr[0] |-> (bus_rdata[31:2] == 30'd0));

    assert_kick_opens_from_one_R3: assert property (@(posedge clk) disable iff (rst)
        (lock_flat[1:0] == 2'd3 && $past(lock_flat[1:0]) != 2'd3) |-> $past(lock_flat[1:0]) == 2'd1);

    assert_enable_opens_from_two_R5: assert property (@(posedge clk) disable iff (rst)
        (lock_flat[5:4] == 2'd3 && $past(lock_flat[5:4]) != 2'd3) |-> $past(lock_flat[5:4]) == 2'd2);

    assert_closed_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 3'd3 && lock_flat[3:2] != 2'd3) |=> $stable(reload_q));

    assert_accept_recloses_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 3'd1 && lock_flat[1:0] == 2'd3) |=> lock_flat[1:0] == 2'd0);

    assert_pulse_needs_run_R10: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(en_q));

    assert_frozen_when_stopped_R11: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !bus_we) |=> $stable(count_q));

endmodule

bind locked_watchdog lwd_check #(.CNT_W(CNT_W)) u_lwd_check (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .rst_req   (rst_req),
    .lock_flat (lock_flat),
    .en_q      (en_q),
    .reload_q  (reload_q),
    .count_q   (count_q)
);

// File: tb/test_locked_watchdog.sv
module test_locked_watchdog;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int n_checks = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    locked_watchdog i_locked_watchdog (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    // ---------------- behavioural reference model ----------------
    int     m_lk [4];
    bit     m_en;
    int     m_rl, m_ps, m_pl;
    longint m_left;
    bit     m_fire;

    function automatic int key_of(int g, int step);
        int keys_kick[2]  = '{32'h5555, 32'hAAAA};
        int keys_rl[2]    = '{32'h6666, 32'hBBBB};
        int keys_en[3]    = '{32'h7777, 32'hCCCC, 32'hDDDD};
        int keys_ps[2]    = '{32'h5A5A, 32'hA5A5};
        if (g == 0) return keys_kick[step];
        if (g == 1) return keys_rl[step];
        if (g == 2) return keys_en[step];
        return keys_ps[step];
    endfunction

    function automatic int next_lock(int g, int s, int w);
        if (g == 2) begin
            if (s < 3 && w == key_of(g, s)) return s + 1;
            return 0;
        end
        if (s == 0 && w == key_of(g, 0)) return 1;
        if (s == 1 && w == key_of(g, 1)) return 3;
        return 0;
    endfunction

    function automatic int model_read(int a);
        int c;
        if (a % 2 == 0) return m_lk[a / 2];
        if (a == 1) begin
            c = int'((m_left + m_pl - 1) / m_pl);
            return c;
        end
        if (a == 3) return m_rl;
        if (a == 5) return int'(m_en);
        return m_ps;
    endfunction

    always @(posedge clk) begin
        int  g, ec, ep;
        bit  ld;
        int  new_lk [4];
        bit  new_en;
        int  new_rl, new_ps;
        if (rst) begin
            for (int i = 0; i < 4; i++) m_lk[i] = 0;
            m_en = 0; m_rl = 32'hFFFF; m_ps = 32'hFFFF; m_pl = 32'hFFFF;
            m_left = 64'hFFFE * 64'hFFFF + 1;
            m_fire = 0;
        end else begin
            ec = (m_rl == 0) ? 1 : m_rl;
            ep = (m_ps == 0) ? 1 : m_ps;
            for (int i = 0; i < 4; i++) new_lk[i] = m_lk[i];
            new_en = m_en; new_rl = m_rl; new_ps = m_ps;
            ld = 0;
            g = int'(bus_addr) / 2;
            if (bus_we) begin
                if (bus_addr[0] == 1'b0) begin
                    new_lk[g] = next_lock(g, m_lk[g], int'(bus_wdata));
                end else if (m_lk[g] == 3) begin
                    new_lk[g] = 0;
                    if (g == 0) ld = 1;
                    if (g == 1) new_rl = int'(bus_wdata[15:0]);
                    if (g == 2) begin
                        if (bus_wdata[0] && !m_en) ld = 1;
                        new_en = bus_wdata[0];
                    end
                    if (g == 3) new_ps = int'(bus_wdata[15:0]);
                end
            end
            m_fire = 0;
            if (ld) begin
                m_left = longint'(ec) * ep; m_pl = ep;
            end else if (m_en) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_fire = 1;
                    m_left = longint'(ec) * ep; m_pl = ep;
                end
            end
            for (int i = 0; i < 4; i++) m_lk[i] = new_lk[i];
            m_en = new_en; m_rl = new_rl; m_ps = new_ps;
        end
    end

    task automatic check(bit ok, string req, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // every clock: compare read data and the reset request against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(bus_rdata == 32'(model_read(int'(bus_addr))), "R1 model read",
                  bus_rdata, model_read(int'(bus_addr)));
            check(rst_req == m_fire, "R10 model pulse", rst_req, m_fire);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); #1;
        bus_addr = a; bus_we = 1'b0;
        #1;
        check(bus_rdata == exp, req, bus_rdata, exp);
    endtask

    task automatic read_now(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk); #1;
        bus_addr = a; bus_we = 1'b0;
        #1;
        v = bus_rdata;
    endtask

    // counts rising edges from the last write's edge until rst_req is seen
    task automatic measure(output int n);
        n = 0;
        for (int k = 0; k < 200; k++) begin
            @(posedge clk); #1;
            n++;
            if (rst_req) break;
        end
    endtask

    task automatic open_enable();
        wr(3'd4, 32'h7777); wr(3'd4, 32'hCCCC); wr(3'd4, 32'hDDDD);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++; n_bad++;
            $display("FAIL watchdog timeout actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        logic [31:0] v0, v1;
        int pulses;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R2 reset state
        peek(3'd0, 32'd0, "R2 kick guard");
        peek(3'd2, 32'd0, "R2 reload guard");
        peek(3'd4, 32'd0, "R2 enable guard");
        peek(3'd6, 32'd0, "R2 prescale guard");
        peek(3'd5, 32'd0, "R2 stopped");
        peek(3'd3, 32'hFFFF, "R2 reload value");
        peek(3'd7, 32'hFFFF, "R2 prescale value");
        check(rst_req == 1'b0, "R2 rst_req low", rst_req, 0);

        // R3 kick guard series, R1 guard read format
        wr(3'd0, 32'h5555);
        peek(3'd0, 32'd1, "R3 kick step1 / R1 upper zero");
        wr(3'd0, 32'hAAAA);
        peek(3'd0, 32'd3, "R3 kick open");
        wr(3'd1, 32'd1);
        peek(3'd0, 32'd0, "R8 kick guard recloses");

        // R6 wrong / out-of-order keys
        wr(3'd0, 32'h5555); wr(3'd0, 32'h1234);
        peek(3'd0, 32'd0, "R6 wrong key");
        wr(3'd0, 32'hAAAA);
        peek(3'd0, 32'd0, "R6 second key first");
        wr(3'd0, 32'h0001_5555);
        peek(3'd0, 32'd0, "R6 key with upper bits");
        wr(3'd0, 32'h5555); wr(3'd0, 32'hAAAA); wr(3'd0, 32'h5555);
        peek(3'd0, 32'd0, "R6 write while open");

        // R7 closed writes ignored
        wr(3'd3, 32'h10);
        peek(3'd3, 32'hFFFF, "R7 reload untouched");
        wr(3'd2, 32'h6666);
        wr(3'd3, 32'h10);
        peek(3'd3, 32'hFFFF, "R7 half-open reload untouched");
        peek(3'd2, 32'd1, "R7 guard state kept");

        // R4 reload and prescale guards
        wr(3'd2, 32'hBBBB);
        peek(3'd2, 32'd3, "R4 reload open");
        wr(3'd3, 32'd4);
        peek(3'd3, 32'd4, "R4 reload written");
        peek(3'd2, 32'd0, "R8 reload guard recloses");
        wr(3'd6, 32'h5A5A);
        peek(3'd6, 32'd1, "R4 prescale step1");
        wr(3'd6, 32'hA5A5);
        peek(3'd6, 32'd3, "R4 prescale open");
        wr(3'd7, 32'd3);
        peek(3'd7, 32'd3, "R4 prescale written");

        // R5 enable guard three steps
        wr(3'd4, 32'h7777);
        peek(3'd4, 32'd1, "R5 enable step1");
        wr(3'd4, 32'hDDDD);
        peek(3'd4, 32'd0, "R5/R6 skipped middle key");
        wr(3'd4, 32'h7777); wr(3'd4, 32'hCCCC);
        peek(3'd4, 32'd2, "R5 enable step2");
        wr(3'd4, 32'hDDDD);
        peek(3'd4, 32'd3, "R5 enable open");

        // R9 start, R10 period = 4 * 3 = 12
        wr(3'd5, 32'd1);
        measure(n);
        check(n == 12, "R10 first period", n, 12);
        @(posedge clk); #1;
        check(rst_req == 1'b0, "R10 single-cycle pulse", rst_req, 0);
        peek(3'd5, 32'd1, "R9 running");

        // R10 kick restarts countdown
        wr(3'd0, 32'h5555); wr(3'd0, 32'hAAAA); wr(3'd1, 32'd1);
        measure(n);
        check(n == 12, "R10 period after kick", n, 12);

        // R10 reload 0 behaves as 1 -> period 3
        wr(3'd2, 32'h6666); wr(3'd2, 32'hBBBB); wr(3'd3, 32'd0);
        wr(3'd0, 32'h5555); wr(3'd0, 32'hAAAA); wr(3'd1, 32'd1);
        measure(n);
        check(n == 3, "R10 zero reload as one", n, 3);

        // R9 stop, R11 frozen
        open_enable();
        wr(3'd5, 32'd0);
        peek(3'd5, 32'd0, "R9 stopped");
        read_now(3'd1, v0);
        pulses = 0;
        for (int k = 0; k < 30; k++) begin
            @(posedge clk); #1;
            if (rst_req) pulses++;
        end
        read_now(3'd1, v1);
        check(v1 == v0, "R11 count frozen", v1, v0);
        check(pulses == 0, "R11 no pulse while stopped", pulses, 0);

        // R9 restart reloads from reload value
        wr(3'd2, 32'h6666); wr(3'd2, 32'hBBBB); wr(3'd3, 32'd5);
        open_enable();
        wr(3'd5, 32'd1);
        peek(3'd1, 32'd5, "R9 start reloads count");
        measure(n);
        check(n == 15, "R10 period 5x3", n, 15);

        repeat (4) @(posedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule